// File: doc/BRIEF.md
# Host Byte Port with Dual Auto-Increment Pointers

This block connects an 8-bit, chip-select-strobed host bus to a video core that runs on its own pixel clock. A 2-bit address and a read/write line choose one of four targets. The targets are a pointer into a control register file, a pointer into a colour lookup table, the control register at that pointer, and the table entry at that pointer. Chip-select and the other host lines are asynchronous. They pass through a two-flop synchronizer, and a falling-edge detector turns the start of each access into a one-cycle strobe.

The control register file spans indices 0x00 to 0x4C. Data writes advance its pointer until it reaches 0x4C, where the pointer stays. Table entries are 24 bits wide: one luma byte and two chroma bytes. The host writes them as three bytes in the order Y, Cb, Cr. A byte counter collects the group and commits the whole entry when the Cr byte arrives, and only then does the table pointer advance. Reads of the table walk the same counter, so an entry comes back in the order it was written. The register contents and the table are visible to the video datapath on dedicated outputs.

Top module: `host_reg_port`

## Requirements
- R1: After reset, both pointers, the table byte counter and every control register read as zero, and the bus enable is low.
- R2: At the falling edge of chip-select the port samples the address and read/write lines, and it samples the data bus on writes. Read/write 0 means write and 1 means read. Address 0 is the control pointer, 1 is the table pointer, 2 is control data at the pointer, and 3 is table data at the pointer.
- R3: Reading address 0 or 1 returns the current value of that pointer.
- R4: A control data write stores the byte at the pointer and then raises the pointer by one.
- R5: A control data write at pointer 0x4C stores the byte and leaves the pointer at 0x4C for every further write.
- R6: When the control pointer is above 0x4C, data writes change no register and do not move the pointer, and data reads return 0.
- R7: Table data bytes are taken as Y, then Cb, then Cr. The entry at the pointer is written as {Y,Cb,Cr} when Cr arrives, and only then does the pointer rise by one.
- R8: Loading the table pointer resets the byte counter to the Y position and discards any partial group.
- R9: A table data read returns the Y, Cb or Cr byte of the entry at the pointer, as selected by the byte counter, and then advances the counter. After the Cr byte it advances the pointer.
- R10: The table pointer wraps from 0xFF to 0x00.
- R11: The bus enable is high only during a read access while chip-select is low, and it drops as soon as chip-select rises. Read data is valid on the bus whenever the enable is high.
- R12: Reading control data does not move the control pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Host chip-select, active low, asynchronous |
| rw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 2 | Target select |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| data_oe_o | output | 1 | Tristate enable for data_o |
| ctrl_regs_o | output | 616 | Control registers, index n at bits [8n+7:8n] |
| lut_idx_i | input | 8 | Datapath table read index |
| lut_entry_o | output | 24 | Table entry at lut_idx_i as {Y,Cb,Cr} |

## Verification
The whole control file is swept with an arithmetic byte pattern, starting from pointer 0. Extra writes then run past 0x4C, which separates correct saturation from wrap or overrun. Table groups are written across the 0xFF boundary and read back byte by byte. Abandoned partial groups and interleaved pointer loads show whether the byte counter resets and when the pointer steps. Out-of-range pointer accesses and repeated control reads show whether the pointer moves on the wrong access types.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int unsigned BW = 8;

  typedef enum logic [1:0] {
    TGT_CPTR  = 2'b00,
    TGT_LPTR  = 2'b01,
    TGT_CDATA = 2'b10,
    TGT_LDATA = 2'b11
  } tgt_e;

  typedef enum logic [1:0] {
    SEL_Y  = 2'd0,
    SEL_CB = 2'd1,
    SEL_CR = 2'd2
  } byte_sel_e;

  typedef struct packed {
    logic [BW-1:0] y;
    logic [BW-1:0] cb;
    logic [BW-1:0] cr;
  } lut_entry_t;
endpackage

// File: rtl/hrp_front.sv
module hrp_front
  import hrp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rw_i,
  input  logic [1:0]    addr_i,
  input  logic [BW-1:0] data_i,
  output logic          strobe_o,
  output logic          cs_n_s_o,
  output logic          rw_s_o,
  output logic [1:0]    addr_s_o,
  output logic [BW-1:0] data_s_o
);
  localparam int unsigned W = BW + 4;

  logic [W-1:0] s1_q, s2_q;
  logic         cs_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= W'(1);
      s2_q   <= W'(1);
      cs_d_q <= 1'b1;
    end else begin
      s1_q   <= {data_i, addr_i, rw_i, cs_ni};
      s2_q   <= s1_q;
      cs_d_q <= s2_q[0];
    end
  end

  assign cs_n_s_o = s2_q[0];
  assign rw_s_o   = s2_q[1];
  assign addr_s_o = s2_q[3:2];
  assign data_s_o = s2_q[W-1:4];
  assign strobe_o = cs_d_q & ~s2_q[0];

  assert_strobe_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/hrp_ctrl_file.sv
module hrp_ctrl_file
  import hrp_pkg::*;
#(
  parameter logic [BW-1:0] CTRL_LAST = 8'h4C,
  localparam int unsigned  NREG      = int'(CTRL_LAST) + 1,
  localparam int unsigned  IDX_W     = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ptr_ld_i,
  input  logic               wr_i,
  input  logic [BW-1:0]      data_i,
  output logic [BW-1:0]      ptr_o,
  output logic [BW-1:0]      rd_byte_o,
  output logic [NREG*BW-1:0] regs_o
);
  logic [BW-1:0] ptr_q;
  logic [BW-1:0] regs_q [NREG];
  logic          in_range;
  logic [IDX_W-1:0] idx;

  assign in_range = (ptr_q <= CTRL_LAST);
  assign idx      = ptr_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (ptr_ld_i) begin
      ptr_q <= data_i;
    end else if (wr_i && in_range) begin
      regs_q[idx] <= data_i;
      if (ptr_q < CTRL_LAST) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr_o     = ptr_q;
  assign rd_byte_o = in_range ? regs_q[idx] : '0;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*BW +: BW] = regs_q[g];
  end

  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ptr_ld_i && ptr_q < CTRL_LAST) |=> ptr_q == BW'($past(ptr_q) + 1'b1));
  assert_ptr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ptr_ld_i && ptr_q >= CTRL_LAST) |=> $stable(ptr_q));
endmodule

// File: rtl/hrp_lut.sv
module hrp_lut
  import hrp_pkg::*;
#(
  parameter  int unsigned AW    = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ptr_ld_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [BW-1:0] data_i,
  output logic [AW-1:0] ptr_o,
  output logic [BW-1:0] rd_byte_o,
  input  logic [AW-1:0] idx_i,
  output lut_entry_t    entry_o
);
  lut_entry_t    mem [DEPTH];
  logic [AW-1:0] ptr_q;
  byte_sel_e     cnt_q;
  logic [BW-1:0] y_q, cb_q;
  lut_entry_t    cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= SEL_Y;
      y_q   <= '0;
      cb_q  <= '0;
    end else if (ptr_ld_i) begin
      ptr_q <= data_i[AW-1:0];
      cnt_q <= SEL_Y;
    end else if (wr_i || rd_i) begin
      if (wr_i && cnt_q == SEL_Y)  y_q  <= data_i;
      if (wr_i && cnt_q == SEL_CB) cb_q <= data_i;
      case (cnt_q)
        SEL_Y:   cnt_q <= SEL_CB;
        SEL_CB:  cnt_q <= SEL_CR;
        default: begin
          cnt_q <= SEL_Y;
          ptr_q <= ptr_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !ptr_ld_i && cnt_q == SEL_CR) mem[ptr_q] <= '{y: y_q, cb: cb_q, cr: data_i};
  end

  assign cur   = mem[ptr_q];
  assign ptr_o = ptr_q;
  always_comb begin
    case (cnt_q)
      SEL_Y:   rd_byte_o = cur.y;
      SEL_CB:  rd_byte_o = cur.cb;
      default: rd_byte_o = cur.cr;
    endcase
  end
  assign entry_o = mem[idx_i];

  always_ff @(posedge clk_i) if (rst_ni) assert_cnt_legal_R7: assert (cnt_q != 2'd3);
  assert_ptr_after_cr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && !ptr_ld_i && cnt_q == SEL_CR) |=> ptr_q == AW'($past(ptr_q) + 1'b1));
  assert_ptr_mid_group_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && !ptr_ld_i && cnt_q != SEL_CR) |=> $stable(ptr_q));
  assert_ld_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_ld_i |=> cnt_q == SEL_Y);
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import hrp_pkg::*;
#(
  parameter  logic [7:0]  CTRL_LAST = 8'h4C,
  parameter  int unsigned LUT_AW    = 8,
  localparam int unsigned NREG      = int'(CTRL_LAST) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               rw_i,
  input  logic [1:0]         addr_i,
  input  logic [7:0]         data_i,
  output logic [7:0]         data_o,
  output logic               data_oe_o,
  output logic [NREG*8-1:0]  ctrl_regs_o,
  input  logic [LUT_AW-1:0]  lut_idx_i,
  output logic [23:0]        lut_entry_o
);
  logic          strobe, cs_n_s, rw_s;
  logic [1:0]    addr_s;
  logic [BW-1:0] data_s;
  tgt_e          tgt;

  hrp_front u_front (
    .clk_i, .rst_ni, .cs_ni, .rw_i, .addr_i, .data_i,
    .strobe_o(strobe), .cs_n_s_o(cs_n_s), .rw_s_o(rw_s),
    .addr_s_o(addr_s), .data_s_o(data_s)
  );

  assign tgt = tgt_e'(addr_s);

  logic wr_acc, rd_acc;
  assign wr_acc = strobe & ~rw_s;
  assign rd_acc = strobe &  rw_s;

  logic [BW-1:0]     c_ptr, c_byte, l_byte;
  logic [LUT_AW-1:0] l_ptr;
  lut_entry_t        l_entry;

  hrp_ctrl_file #(.CTRL_LAST(CTRL_LAST)) u_ctrl (
    .clk_i, .rst_ni,
    .ptr_ld_i (wr_acc && tgt == TGT_CPTR),
    .wr_i     (wr_acc && tgt == TGT_CDATA),
    .data_i   (data_s),
    .ptr_o    (c_ptr),
    .rd_byte_o(c_byte),
    .regs_o   (ctrl_regs_o)
  );

  hrp_lut #(.AW(LUT_AW)) u_lut (
    .clk_i, .rst_ni,
    .ptr_ld_i (wr_acc && tgt == TGT_LPTR),
    .wr_i     (wr_acc && tgt == TGT_LDATA),
    .rd_i     (rd_acc && tgt == TGT_LDATA),
    .data_i   (data_s),
    .ptr_o    (l_ptr),
    .rd_byte_o(l_byte),
    .idx_i    (lut_idx_i),
    .entry_o  (l_entry)
  );
  assign lut_entry_o = l_entry;

  logic [BW-1:0] rd_data_q;
  logic          rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q <= '0;
      rd_q      <= 1'b0;
    end else if (rd_acc) begin
      rd_q <= 1'b1;
      case (tgt)
        TGT_CPTR:  rd_data_q <= c_ptr;
        TGT_LPTR:  rd_data_q <= BW'(l_ptr);
        TGT_CDATA: rd_data_q <= c_byte;
        default:   rd_data_q <= l_byte;
      endcase
    end else if (cs_n_s) begin
      rd_q <= 1'b0;
    end
  end

  // enable drops combinationally with chip-select
  assign data_oe_o = rd_q & ~cs_ni;
  assign data_o    = rd_data_q;

  assert_oe_needs_cs_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !cs_ni);
  assert_oe_not_on_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_acc |=> !rd_q);
endmodule

// File: tb/tb_host_reg_port.sv
`timescale 1ns/1ps
module tb_host_reg_port;
  localparam int NREG = 77;

  logic clk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, rw_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] data_i = '0, data_o, lut_idx_i = '0;
  logic data_oe_o;
  logic [NREG*8-1:0] ctrl_regs_o;
  logic [23:0] lut_entry_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_c [NREG];
  logic [7:0] rb;

  always #2.5 clk = ~clk;

  host_reg_port dut (.clk_i(clk), .rst_ni, .cs_ni, .rw_i, .addr_i, .data_i,
    .data_o, .data_oe_o, .ctrl_regs_o, .lut_idx_i, .lut_entry_o);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(logic rw, logic [1:0] a, logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    rw_i = rw; addr_i = a; data_i = d;
    @(negedge clk);
    cs_ni = 1'b0;
    repeat (5) @(negedge clk);
    q = data_o;
    chk("R11 enable during access", data_oe_o, rw);
    cs_ni = 1'b1;
    #0.5;
    chk("R11 enable drops with cs", data_oe_o, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    logic [7:0] q;
    access(1'b0, a, d, q);
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] q);
    access(1'b1, a, 8'h00, q);
  endtask

  task automatic chk_regs(string req);
    for (int i = 0; i < NREG; i++) chk(req, ctrl_regs_o[i*8 +: 8], exp_c[i]);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) exp_c[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1
    chk("R1 oe", data_oe_o, 0);
    chk_regs("R1 regs");
    rd(2'd0, rb); chk("R1 ctrl ptr", rb, 0);
    rd(2'd1, rb); chk("R1 lut ptr", rb, 0);

    // R4 R5 sweep with overrun
    wr(2'd0, 8'h00);
    for (int i = 0; i < NREG + 3; i++) begin
      logic [7:0] v = 8'((i * 7 + 3) & 255);
      wr(2'd2, v);
      exp_c[i < NREG ? i : NREG - 1] = v;
    end
    chk_regs("R4 sweep");
    rd(2'd0, rb); chk("R5 saturated ptr", rb, 8'h4C);
    wr(2'd0, 8'h4B); wr(2'd2, 8'hA1); wr(2'd2, 8'hA2); wr(2'd2, 8'hA3);
    exp_c[75] = 8'hA1; exp_c[76] = 8'hA3;
    chk_regs("R5 last write stays");
    rd(2'd0, rb); chk("R5 ptr holds", rb, 8'h4C);

    // R3 R2: pointers distinct
    wr(2'd0, 8'h05); wr(2'd1, 8'h3C);
    rd(2'd0, rb); chk("R3 ctrl ptr readback", rb, 8'h05);
    rd(2'd1, rb); chk("R2 lut ptr separate", rb, 8'h3C);

    // R12 read does not move ptr, R2 read returns data
    for (int k = 0; k < 3; k++) begin
      rd(2'd2, rb); chk("R12 ctrl read", rb, exp_c[5]);
    end
    rd(2'd0, rb); chk("R12 ptr unmoved", rb, 8'h05);
    for (int i = 0; i < NREG; i += 19) begin
      wr(2'd0, 8'(i)); rd(2'd2, rb); chk("R2 ctrl readback", rb, exp_c[i]);
    end

    // R6 out-of-range
    wr(2'd0, 8'h80); wr(2'd2, 8'h55);
    chk_regs("R6 no write");
    rd(2'd2, rb); chk("R6 read zero", rb, 0);
    rd(2'd0, rb); chk("R6 ptr fixed", rb, 8'h80);

    // R7 R10 groups across wrap
    wr(2'd1, 8'hFE);
    for (int e = 0; e < 3; e++) begin
      for (int b = 0; b < 3; b++) begin
        wr(2'd3, 8'(16 * e + b + 1));
        if (b < 2) begin
          rd(2'd1, rb); chk("R7 ptr mid group", rb, 8'(8'hFE + e));
        end
      end
    end
    rd(2'd1, rb); chk("R10 ptr wrapped", rb, 8'h01);
    for (int e = 0; e < 3; e++) begin
      lut_idx_i = 8'(8'hFE + e); #1;
      chk("R7 entry packed", lut_entry_o, {8'(16*e+1), 8'(16*e+2), 8'(16*e+3)});
    end

    // R8 partial group discarded
    wr(2'd1, 8'h10); wr(2'd3, 8'hEE); wr(2'd3, 8'hDD);
    wr(2'd1, 8'h20); wr(2'd3, 8'h11); wr(2'd3, 8'h22); wr(2'd3, 8'h33);
    lut_idx_i = 8'h20; #1;
    chk("R8 counter cleared", lut_entry_o, 24'h112233);
    rd(2'd1, rb); chk("R8 ptr after group", rb, 8'h21);

    // R9 read back in order
    wr(2'd1, 8'hFE);
    for (int e = 0; e < 3; e++)
      for (int b = 0; b < 3; b++) begin
        rd(2'd3, rb); chk("R9 byte order", rb, 8'(16 * e + b + 1));
      end
    rd(2'd1, rb); chk("R9 R10 ptr after reads", rb, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule